// File: doc/BRIEF.md
# Serial HDLC Frame Receiver with Position-Tagged Byte Queue

This block takes a bit-serial line, one bit per cycle in which `bit_valid` is high. It finds the flag octets that delimit frames and removes the zero bits that the sender inserted for transparency. It packs the frame contents into bytes, first bit received in bit 0. Every byte that carries address, control or information content goes into a small queue together with a 2-bit position tag. The tag tells software where a packet starts and where it ends, and whether the packet passed its check. The two check octets at the tail of each frame are never queued. Instead they are checked with a CRC, and their raw received form is kept in a register.

The line side has no back-pressure, because a receiver cannot stall the wire. Each `bit_valid` cycle is consumed at once. The read side is a valid/ready stream: a byte and its tag leave the queue on every cycle where both `out_valid` and `out_ready` are high. While `out_ready` is low, the head entry is held steady. When the queue fills, the packet being received is cut off until the next flag, and nothing already stored is touched. Two interrupt lines flag end-of-packet bytes: one when such a byte is written, one while such a byte is at the head of the queue.

Top module: `hdlc_rx`

## Requirements
- R1: A flag is the bit pattern 0x7E (a zero, six ones, a zero). Bits are ignored until a flag is seen, and every flag closes any open frame and opens a new one.
- R2: Inside a frame, a zero that follows five consecutive ones is deleted and never reaches a byte. Payload such as 0xFF or 0x7E is therefore stored unchanged.
- R3: Each queue entry holds a data byte (`out_data`, first received bit in bit 0) and a tag (`out_tag`). The tags are 01 for the first byte of a packet, 00 for a middle byte, 10 for the last byte of a good packet, and 11 for the last byte of a bad packet.
- R4: The 16 bits just before the closing flag are the FCS. They are never written to the queue.
- R5: A packet is good only when three things hold: it carries at least 32 bits between its flags, its bit count is a multiple of 8, and the CRC-16 (polynomial x^16+x^12+x^5+1, LSB first, preset all ones, run over data and FCS) leaves the residue 0xF0B8. Otherwise its last byte is tagged 11.
- R6: A frame of fewer than 24 bits between flags writes nothing. A frame of 24 to 31 bits writes its single byte tagged 11.
- R7: Seven or more consecutive ones abort the frame. A byte already received but not yet stored is written tagged 11, and the receiver then waits for a flag.
- R8: At each closing flag that ends at least 16 frame bits, `rx_fcs` takes the 16 bits before the flag as they arrived: `rx_fcs[15]` is the first FCS bit received, and the bits are not inverted back. The register holds its value between closing flags.
- R9: If a byte arrives while the queue is full, that byte and every later byte of the same packet, its end byte included, are dropped. The stored entries stay unchanged, and writing resumes with the packet after the next flag.
- R10: `irq_eop_wr` pulses for one cycle, on the cycle after a byte tagged 10 or 11 enters the queue. `irq_eop_rd` is high exactly while `out_valid` is high and the head tag is 10 or 11.
- R11: Raising `rx_en` takes effect at once, but a frame already in progress is ignored until a flag is seen. Lowering `rx_en` takes effect at once if the current packet has produced no byte yet; otherwise it takes effect after that packet ends. While the receiver is disabled, line bits are ignored and the read side keeps working.
- R12: After reset the queue is empty, both interrupts are low and `rx_fcs` is zero. While `out_valid` is high and `out_ready` is low, the head entry is held unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_en | input | 1 | Receiver enable |
| bit_valid | input | 1 | Line bit strobe, one bit per high cycle |
| bit_in | input | 1 | Line bit |
| out_valid | output | 1 | Queue head is valid |
| out_ready | input | 1 | Consumer accepts the head entry |
| out_data | output | 8 | Head data byte |
| out_tag | output | 2 | Head position tag |
| rx_fcs | output | 16 | Last received FCS, raw |
| irq_eop_wr | output | 1 | End-of-packet byte written (pulse) |
| irq_eop_rd | output | 1 | End-of-packet byte at queue head |

## Verification
A data byte is produced by the line bit that completes the 8 bits following it, plus the 22 bits of FCS and flag prefix after that. The byte is then held in a one-byte register until the next byte or the frame end arrives. It reaches the queue one cycle after its producing bit, and `out_valid` shows it on the cycle after that. `irq_eop_wr` rises on the same cycle that the entry becomes visible. `rx_fcs` changes one cycle after the flag's final zero. The scoreboard therefore compares entries in order at each accepted handshake rather than at fixed cycles. The bench drives inputs one time step after a rising edge and samples on falling edges. The FCS register is checked only after the closing flag and several idle cycles.

// File: rtl/hdlc_rx_pkg.sv
package hdlc_rx_pkg;

  typedef enum logic [1:0] {
    TAG_MID     = 2'b00,
    TAG_FIRST   = 2'b01,
    TAG_EOP_OK  = 2'b10,
    TAG_EOP_BAD = 2'b11
  } tag_e;

  typedef struct packed {
    tag_e       tag;
    logic [7:0] data;
  } entry_t;

  localparam logic [15:0] CRC_POLY_REFL = 16'h8408;
  localparam logic [15:0] CRC_INIT      = 16'hFFFF;
  localparam logic [15:0] CRC_RESIDUE   = 16'hF0B8;

endpackage

// File: rtl/hdlc_rx_crc.sv
module hdlc_rx_crc #(
  parameter int          W    = 16,
  parameter logic [15:0] POLY = hdlc_rx_pkg::CRC_POLY_REFL,
  parameter logic [15:0] INIT = hdlc_rx_pkg::CRC_INIT
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         en_i,
  input  logic         bit_i,
  output logic [W-1:0] crc_o
);

  logic [W-1:0] crc_q;
  logic [W-1:0] crc_nx;

  always_comb begin
    crc_nx = {1'b0, crc_q[W-1:1]};
    if (crc_q[0] ^ bit_i) crc_nx = crc_nx ^ POLY[W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      crc_q <= INIT[W-1:0];
    else if (clr_i)  crc_q <= INIT[W-1:0];
    else if (en_i)   crc_q <= crc_nx;
  end

  assign crc_o = crc_q;

endmodule

// File: rtl/hdlc_rx_deframer.sv
module hdlc_rx_deframer
  import hdlc_rx_pkg::*;
#(
  parameter int FCS_W    = 16,
  parameter int MIN_BITS = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_en_i,
  input  logic             bit_valid_i,
  input  logic             bit_i,
  output logic             wr_o,
  output entry_t           wr_ent_o,
  output logic             sof_o,
  output logic [FCS_W-1:0] fcs_o
);

  localparam int BYTE_W = 8;
  localparam int DLY    = 6;                        // flag bits accepted before detection
  localparam int WIN    = BYTE_W + FCS_W + DLY;     // bits seen before a byte is known data
  localparam int SR_W   = WIN - 1;
  localparam int CNT_W  = $clog2(MIN_BITS + DLY + 1);
  localparam logic [CNT_W-1:0] CNT_MAX   = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] EMIT_MIN  = CNT_W'(WIN);
  localparam logic [CNT_W-1:0] CLOSE_MIN = CNT_W'(MIN_BITS + DLY);
  localparam logic [CNT_W-1:0] FCS_MIN   = CNT_W'(FCS_W + DLY);
  localparam logic [CNT_W-1:0] DLY_C     = CNT_W'(DLY);
  localparam logic [2:0]       EMIT_PH   = 3'(WIN % BYTE_W);
  localparam logic [2:0]       ALIGN_PH  = 3'(DLY % BYTE_W);

  logic [2:0]       ones_q;
  logic             in_frame_q, started_q, held_v_q, held_first_q;
  logic [7:0]       held_q;
  logic [SR_W-1:0]  sr_q;
  logic [CNT_W-1:0] cnt_q;
  logic [2:0]       ph_q;
  logic [FCS_W-1:0] fcs_q;
  logic             wr_q, sof_q;
  entry_t           wr_ent_q;

  logic             active, step, is_flag, is_stuff, is_abort, accept, close, emit, frame_ok;
  logic [CNT_W-1:0] cnt_nx;
  logic [2:0]       ph_nx;
  logic [7:0]       new_byte;
  logic [15:0]      crc_w;

  assign active   = rx_en_i | started_q;
  assign step     = bit_valid_i & active;
  assign is_flag  = step & ~bit_i & (ones_q == 3'd6);
  assign is_stuff = step & ~bit_i & (ones_q == 3'd5);
  assign is_abort = step &  bit_i & (ones_q == 3'd6);
  assign accept   = step & in_frame_q & ~is_flag & ~is_stuff & ~(bit_i & (ones_q >= 3'd5));
  assign close    = is_flag & in_frame_q;
  assign cnt_nx   = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + 1'b1;
  assign ph_nx    = ph_q + 3'd1;
  assign emit     = accept & (cnt_nx >= EMIT_MIN) & (ph_nx == EMIT_PH);
  assign frame_ok = (cnt_q >= CLOSE_MIN) & (ph_q == ALIGN_PH) & (crc_w == CRC_RESIDUE);

  always_comb begin
    for (int i = 0; i < BYTE_W; i++) new_byte[i] = sr_q[SR_W-1-i];
  end

  hdlc_rx_crc #(.W(16)) u_crc (
    .clk   (clk),
    .rst_n (rst_n),
    .clr_i (is_flag | is_abort | ~active),
    .en_i  (accept & (cnt_q >= DLY_C)),
    .bit_i (sr_q[DLY-1]),
    .crc_o (crc_w)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ones_q <= '0; in_frame_q <= 1'b0; started_q <= 1'b0;
      held_v_q <= 1'b0; held_first_q <= 1'b0; held_q <= '0;
      sr_q <= '0; cnt_q <= '0; ph_q <= '0; fcs_q <= '0;
      wr_q <= 1'b0; sof_q <= 1'b0; wr_ent_q <= '0;
    end else begin
      wr_q  <= 1'b0;
      sof_q <= 1'b0;
      if (!active) begin
        ones_q <= '0; in_frame_q <= 1'b0; cnt_q <= '0; ph_q <= '0; held_v_q <= 1'b0;
      end else if (bit_valid_i) begin
        ones_q <= bit_i ? ((ones_q == 3'd7) ? ones_q : ones_q + 3'd1) : 3'd0;
        if (is_flag || is_abort) begin
          if (in_frame_q && held_v_q) begin
            wr_q          <= 1'b1;
            wr_ent_q.data <= held_q;
            wr_ent_q.tag  <= (is_flag && frame_ok) ? TAG_EOP_OK : TAG_EOP_BAD;
          end
          if (close && (cnt_q >= FCS_MIN)) fcs_q <= sr_q[FCS_W+DLY-1:DLY];
          in_frame_q <= is_flag & rx_en_i;
          sof_q      <= is_flag & rx_en_i;
          cnt_q <= '0; ph_q <= '0; held_v_q <= 1'b0; started_q <= 1'b0;
        end else if (accept) begin
          sr_q  <= {sr_q[SR_W-2:0], bit_i};
          cnt_q <= cnt_nx;
          ph_q  <= ph_nx;
          if (emit) begin
            if (held_v_q) begin
              wr_q          <= 1'b1;
              wr_ent_q.data <= held_q;
              wr_ent_q.tag  <= held_first_q ? TAG_FIRST : TAG_MID;
            end
            held_q       <= new_byte;
            held_v_q     <= 1'b1;
            held_first_q <= ~started_q;
            started_q    <= 1'b1;
          end
        end
      end
    end
  end

  assign wr_o     = wr_q;
  assign wr_ent_o = wr_ent_q;
  assign sof_o    = sof_q;
  assign fcs_o    = fcs_q;

  // R8: the captured FCS moves only on a closing flag
  a_r8_fcs_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !close |=> $stable(fcs_q));
  // R3: an end byte leaves no packet open behind it
  a_r3_eop_ends_pkt: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_q && wr_ent_q.tag[1]) |-> (!started_q && !held_v_q));
  // R3: a first or middle byte always has a successor pending
  a_r3_mid_has_next: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_q && !wr_ent_q.tag[1]) |-> (started_q && held_v_q));
  // R11: disabled with no byte produced means no open frame next cycle
  a_r11_idle_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_en_i && !started_q) |=> !in_frame_q);

endmodule

// File: rtl/hdlc_rx_fifo.sv
module hdlc_rx_fifo
  import hdlc_rx_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   wr_i,
  input  entry_t wr_ent_i,
  input  logic   sof_i,
  output logic   wr_ok_o,
  output logic   rd_valid_o,
  input  logic   rd_ready_i,
  output entry_t rd_ent_o
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  entry_t        mem_q [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [CW-1:0] count_q;
  logic          lock_q;
  logic          full_w, push_w, pop_w;

  assign full_w     = (count_q == FULL);
  assign push_w     = wr_i & ~lock_q & ~full_w;
  assign pop_w      = rd_valid_o & rd_ready_i;
  assign rd_valid_o = (count_q != '0);
  assign rd_ent_o   = mem_q[rp_q];
  assign wr_ok_o    = push_w;

  always_ff @(posedge clk) begin
    if (push_w) mem_q[wp_q] <= wr_ent_i;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp_q <= '0; rp_q <= '0; count_q <= '0; lock_q <= 1'b0;
    end else begin
      if (push_w) wp_q <= (wp_q == LAST) ? '0 : wp_q + 1'b1;
      if (pop_w)  rp_q <= (rp_q == LAST) ? '0 : rp_q + 1'b1;
      case ({push_w, pop_w})
        2'b10:   count_q <= count_q + 1'b1;
        2'b01:   count_q <= count_q - 1'b1;
        default: count_q <= count_q;
      endcase
      if (sof_i)              lock_q <= 1'b0;
      else if (wr_i && full_w) lock_q <= 1'b1;
    end
  end

  // R9: a full queue with no pop stays full
  a_r9_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (full_w && !pop_w) |=> (count_q == FULL));
  // R9: while frozen, no entry is added
  a_r9_lock_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q && !sof_i && !pop_w) |=> $stable(count_q));
  // R12: a stalled head entry does not change
  a_r12_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid_o && !rd_ready_i) |=> (rd_valid_o && $stable(rd_ent_o)));

endmodule

// File: rtl/hdlc_rx.sv
module hdlc_rx
  import hdlc_rx_pkg::*;
#(
  parameter int DEPTH    = 16,
  parameter int FCS_W    = 16,
  parameter int MIN_BITS = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_en,
  input  logic             bit_valid,
  input  logic             bit_in,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [7:0]       out_data,
  output logic [1:0]       out_tag,
  output logic [FCS_W-1:0] rx_fcs,
  output logic             irq_eop_wr,
  output logic             irq_eop_rd
);

  logic   wr_w, sof_w, wr_ok_w;
  entry_t wr_ent_w, head_w;
  logic   eopd_q;

  hdlc_rx_deframer #(.FCS_W(FCS_W), .MIN_BITS(MIN_BITS)) u_deframer (
    .clk         (clk),
    .rst_n       (rst_n),
    .rx_en_i     (rx_en),
    .bit_valid_i (bit_valid),
    .bit_i       (bit_in),
    .wr_o        (wr_w),
    .wr_ent_o    (wr_ent_w),
    .sof_o       (sof_w),
    .fcs_o       (rx_fcs)
  );

  hdlc_rx_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_i       (wr_w),
    .wr_ent_i   (wr_ent_w),
    .sof_i      (sof_w),
    .wr_ok_o    (wr_ok_w),
    .rd_valid_o (out_valid),
    .rd_ready_i (out_ready),
    .rd_ent_o   (head_w)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) eopd_q <= 1'b0;
    else        eopd_q <= wr_ok_w & wr_ent_w.tag[1];
  end

  assign out_data   = head_w.data;
  assign out_tag    = head_w.tag;
  assign irq_eop_wr = eopd_q;
  assign irq_eop_rd = out_valid & head_w.tag[1];

  // R10: a just-written end byte is in the queue
  a_r10_eopd_visible: assert property (@(posedge clk) disable iff (!rst_n)
    irq_eop_wr |-> out_valid);
  // R10: the write interrupt is a single-cycle pulse
  a_r10_eopd_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    irq_eop_wr |=> (!irq_eop_wr || $past(wr_ok_w)));

endmodule

// File: tb/hdlc_rx_tb.sv
module hdlc_rx_tb;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n, rx_en, bit_valid, bit_in, out_valid, out_ready;
  logic [7:0]  out_data;
  logic [1:0]  out_tag;
  logic [15:0] rx_fcs;
  logic        irq_eop_wr, irq_eop_rd;

  hdlc_rx u_dut (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .bit_valid(bit_valid), .bit_in(bit_in),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_tag(out_tag),
    .rx_fcs(rx_fcs), .irq_eop_wr(irq_eop_wr), .irq_eop_rd(irq_eop_rd)
  );

  int          n_chk = 0, n_bad = 0, eop_exp = 0, eop_seen = 0, ones_tx = 0;
  logic [9:0]  sbq[$];
  logic [7:0]  pl [0:39];
  logic [15:0] crc_m, fcs_sent;
  string       cur_req = "R12";
  logic        done = 1'b0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(); @(posedge clk); #1; endtask

  task automatic raw_bit(input logic b);
    bit_valid = 1'b1; bit_in = b; tick();
    bit_valid = 1'b0; tick();
  endtask

  task automatic data_bit(input logic b);
    raw_bit(b);
    if (b) begin
      ones_tx++;
      if (ones_tx == 5) begin raw_bit(1'b0); ones_tx = 0; end
    end else ones_tx = 0;
  endtask

  task automatic flag();
    raw_bit(1'b0);
    for (int i = 0; i < 6; i++) raw_bit(1'b1);
    raw_bit(1'b0);
    ones_tx = 0;
  endtask

  task automatic crc_bit(input logic b);
    logic fb;
    fb = crc_m[0] ^ b;
    crc_m = crc_m >> 1;
    if (fb) crc_m = crc_m ^ 16'h8408;
  endtask

  task automatic begin_frame(); crc_m = 16'hFFFF; ones_tx = 0; endtask

  task automatic data_byte(input logic [7:0] v);
    for (int i = 0; i < 8; i++) begin crc_bit(v[i]); data_bit(v[i]); end
  endtask

  // mode 0 good, 1 corrupted FCS, 2 three extra bits (misaligned)
  task automatic end_frame(input int mode);
    logic [15:0] f;
    f = ~crc_m;
    if (mode == 1) f[3] = ~f[3];
    for (int i = 0; i < 16; i++) data_bit(f[i]);
    if (mode == 2) begin data_bit(1'b1); data_bit(1'b0); data_bit(1'b1); end
    fcs_sent = f;
    flag();
  endtask

  task automatic send_pkt(input int n, input int mode);
    begin_frame();
    for (int i = 0; i < n; i++) data_byte(pl[i]);
    end_frame(mode);
  endtask

  task automatic push_exp(input int n, input logic [1:0] last_tag);
    for (int i = 0; i < n; i++)
      sbq.push_back({(i == n-1) ? last_tag : ((i == 0) ? 2'b01 : 2'b00), pl[i]});
    if (n > 0) eop_exp++;
  endtask

  task automatic drain(input string req);
    for (int i = 0; i < 3000 && sbq.size() > 0; i++) tick();
    repeat (20) tick();
    chk(req, sbq.size(), 0);
  endtask

  function automatic logic [15:0] fcs_raw(input logic [15:0] f);
    logic [15:0] r;
    for (int i = 0; i < 16; i++) r[15-i] = f[i];
    return r;
  endfunction

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (irq_eop_wr) eop_seen++;
      if (out_valid) chk({cur_req, " R10 eop-read irq"}, irq_eop_rd, out_tag[1]);
      if (out_valid && out_ready) begin
        if (sbq.size() == 0) chk({cur_req, " R3 unexpected entry"}, {out_tag, out_data}, 32'hDEAD);
        else begin
          logic [9:0] e;
          e = sbq.pop_front();
          chk({cur_req, " R3 entry"}, {out_tag, out_data}, e);
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [9:0] held;
    rst_n = 1'b0; rx_en = 1'b0; bit_valid = 1'b0; bit_in = 1'b0; out_ready = 1'b1;
    for (int i = 0; i < 40; i++) pl[i] = 8'(i * 37 + 5);
    pl[0] = 8'hFF; pl[1] = 8'h7E; pl[2] = 8'h3F;
    repeat (4) tick();
    chk("R12 reset valid", out_valid, 0);
    chk("R12 reset irq", {irq_eop_wr, irq_eop_rd}, 0);
    chk("R12 reset fcs", rx_fcs, 0);
    rst_n = 1'b1; tick();

    // R1/R2/R4: good packet with stuffing-heavy payload
    cur_req = "R1/R2/R4"; rx_en = 1'b1;
    for (int i = 0; i < 10; i++) raw_bit(1'b1);
    flag(); flag();
    push_exp(4, 2'b10); send_pkt(4, 0);
    drain("R2/R4 drained");
    chk("R8 fcs raw", rx_fcs, fcs_raw(fcs_sent));

    cur_req = "R5 bad crc";
    push_exp(3, 2'b11); send_pkt(3, 1);
    drain("R5 drained");
    chk("R8 fcs raw bad", rx_fcs, fcs_raw(fcs_sent));

    cur_req = "R5 misaligned";
    push_exp(3, 2'b11); send_pkt(3, 2);
    drain("R5 misaligned drained");

    cur_req = "R6 short";
    push_exp(1, 2'b11); send_pkt(1, 0);
    send_pkt(0, 0);
    drain("R6 drained");

    cur_req = "R7 abort";
    begin_frame();
    data_byte(8'h12); data_byte(8'h34); data_byte(8'h56); data_byte(8'h00);
    sbq.push_back({2'b11, 8'h12}); eop_exp++;
    for (int i = 0; i < 8; i++) raw_bit(1'b1);
    flag();
    push_exp(3, 2'b10); send_pkt(3, 0);
    drain("R7 drained");

    cur_req = "R9 overflow";
    out_ready = 1'b0;
    begin_frame();
    for (int i = 0; i < 22; i++) data_byte(pl[i]);
    for (int i = 0; i < 16; i++) sbq.push_back({(i == 0) ? 2'b01 : 2'b00, pl[i]});
    held = {out_tag, out_data};
    repeat (5) tick();
    chk("R12 stall hold", {out_valid, out_tag, out_data}, {1'b1, held});
    out_ready = 1'b1;
    for (int i = 22; i < 30; i++) data_byte(pl[i]);
    end_frame(0);
    push_exp(3, 2'b10); send_pkt(3, 0);
    drain("R9 drained");

    cur_req = "R11 disabled";
    rx_en = 1'b0;
    flag(); send_pkt(3, 0); flag();
    repeat (20) tick();
    chk("R11 disabled ignores", out_valid, 0);

    cur_req = "R1/R11 mid enable";
    begin_frame(); data_byte(pl[0]); data_byte(pl[1]);
    rx_en = 1'b1;
    data_byte(pl[2]); data_byte(pl[3]); end_frame(0);
    push_exp(3, 2'b10); send_pkt(3, 0);
    drain("R11 mid enable drained");

    cur_req = "R11 deferred disable";
    push_exp(8, 2'b10);
    begin_frame();
    for (int i = 0; i < 6; i++) data_byte(pl[i]);
    rx_en = 1'b0;
    data_byte(pl[6]); data_byte(pl[7]); end_frame(0);
    send_pkt(3, 0); flag();
    drain("R11 deferred drained");

    cur_req = "R11 immediate disable";
    rx_en = 1'b1; flag();
    begin_frame(); data_byte(pl[0]); data_byte(pl[1]);
    rx_en = 1'b0;
    data_byte(pl[2]); data_byte(pl[3]); end_frame(0);
    repeat (20) tick();
    chk("R11 immediate drop", out_valid, 0);
    rx_en = 1'b1; flag();
    push_exp(2, 2'b10); send_pkt(2, 0);
    drain("R11 re-enable drained");

    repeat (10) tick();
    chk("R10 eop write pulses", eop_seen, eop_exp);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule